// File: doc/BRIEF.md
# Status-Change Interrupt Latch

This block sits beside one channel of a serial controller and watches six status conditions: a zero-count pulse from the baud counter, carrier detect, clear-to-send, a transmit underrun/end-of-message flag, a break/abort flag, and a sync/hunt flag. The sync/hunt flag is held inside the block. A hunt command sets it and a sync-found indication from the receiver clears it. Each source has its own enable bit. The status word that software reads shows every disabled source live. Enabled sources pass through one shared snapshot latch.

The latch closes when any enabled source changes state. All enabled bits are then frozen at the values they held when the change was seen. They stay frozen until software issues the reopen command. While the latch is closed, the interrupt-pending output is high, provided the master enable is set.

Software must keep its own copy of the status word. After an interrupt, it compares the frozen bits against that copy to find out which source moved. The zero-count source is the exception, because it may leave no lasting trace. Software then reopens the latch.

Top module: `stat_irq_latch`

## Requirements
- R1: Register address 0 holds the source enables: bit 7 break/abort, bit 6 underrun/end-of-message, bit 5 clear-to-send, bit 4 sync/hunt, bit 3 carrier detect, bit 1 zero count. Bits 2 and 0 cannot be set and read back 0. Address 1 bit 0 is the master enable, and its other bits read 0. Writes take effect on the clock edge on which they are sampled.
- R2: Address 2 reads the status word, using the same bit positions as R1, with bits 2 and 0 reading 0. The bit of a disabled source always shows the live input, whether the latch is open or closed.
- R3: When the latch is open and an enabled source changes, the latch closes on the next clock edge. Every enabled bit then reads the value its input had in the cycle the change was seen.
- R4: While the latch is closed, the enabled bits hold their frozen values whatever the inputs do. Further changes are not recorded.
- R5: A one-cycle pulse on the reopen command opens the latch at the next edge. From then on, the enabled bits follow their live inputs.
- R6: A change on a source whose enable bit is 0 never closes the latch, even with the master enable set.
- R7: irq_pend is high exactly while the latch is closed and the master enable is 1. With the master enable at 0, the latch still closes and freezes, but irq_pend stays 0.
- R8: A hunt command sets the sync/hunt flag at the next edge, and a sync-found pulse clears it. If both arrive in the same cycle, the hunt command wins. When the sync/hunt source is enabled, both the rising and falling transitions of the flag close the latch.
- R9: When enabled, a one-cycle high pulse on the zero-count input closes the latch. The zero-count status bit shows the pulse level, so while the latch is closed it reads the frozen 1.
- R10: If the reopen command and an enabled change arrive in the same cycle, the latch is open for one cycle. It then closes again on the following edge and freezes the values from the cycle of the change.
- R11: With rst_n low at a clock edge, all enables, the master enable and the sync/hunt flag clear, the latch opens, and irq_pend goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| zc_pulse | input | 1 | Zero-count pulse from the baud counter |
| dcd_in | input | 1 | Carrier detect level |
| cts_in | input | 1 | Clear-to-send level |
| txund_in | input | 1 | Transmit underrun / end-of-message level |
| brk_in | input | 1 | Break / abort level |
| hunt_cmd | input | 1 | Enter-hunt command pulse |
| sync_found | input | 1 | Character synchronization reported by the receiver |
| reopen_cmd | input | 1 | Reopen-latch command pulse |
| irq_pend | output | 1 | Interrupt pending |

## Verification
The assertions assume that every command input (hunt_cmd, sync_found, reopen_cmd) and the register strobe are only high for whole cycles aligned to the clock. They also assume that the zero-count input is a pulse rather than a held level. Held-high zero count would close the latch again immediately after each reopen. The stimulus changes every input on the falling clock edge, drives zero count high for exactly one cycle, and holds each command for one cycle. This keeps every input change a clean single-edge event, so each closure can be placed on a known edge.

// File: rtl/stat_irq_pkg.sv
// Package: shared constants and types for the status-change interrupt latch.
// Assumes an 8-bit register port and a 2-bit register address.
package stat_irq_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    // Bit positions of each source in the enable and status words.
    localparam int BIT_BRK  = 7;
    localparam int BIT_TXU  = 6;
    localparam int BIT_CTS  = 5;
    localparam int BIT_HUNT = 4;
    localparam int BIT_DCD  = 3;
    localparam int BIT_ZC   = 1;

    // Positions that carry a source; the others read zero.
    localparam logic [DATA_W-1:0] SRC_MASK =
        (DATA_W'(1) << BIT_BRK) | (DATA_W'(1) << BIT_TXU) |
        (DATA_W'(1) << BIT_CTS) | (DATA_W'(1) << BIT_HUNT) |
        (DATA_W'(1) << BIT_DCD) | (DATA_W'(1) << BIT_ZC);

    // Level sources detect any transition; zero count detects a high level.
    localparam logic [DATA_W-1:0] LEVEL_MASK = SRC_MASK & ~(DATA_W'(1) << BIT_ZC);
    localparam logic [DATA_W-1:0] PULSE_MASK = DATA_W'(1) << BIT_ZC;

    typedef enum logic [ADDR_W-1:0] {
        ADR_ENABLE = 2'd0,
        ADR_MASTER = 2'd1,
        ADR_STATUS = 2'd2,
        ADR_SPARE  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/stat_cfg_regs.sv
// Module: stat_cfg_regs
// Holds the per-source enable byte and the master enable bit.
// Assumes: single-cycle write strobe; unused enable positions are forced to 0.
module stat_cfg_regs
    import stat_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] src_en,
    output logic              master_en
);
    // Only bit 0 of the master byte is stored.
    logic unused_ctl_bits;
    assign unused_ctl_bits = ^wr_data[DATA_W-1:1];

    // Purpose: capture software writes to the two control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en    <= '0;
            master_en <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADR_ENABLE) src_en    <= wr_data & SRC_MASK;
            if (wr_addr == ADR_MASTER) master_en <= wr_data[0];
        end
    end

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_ENABLE) |=> (src_en == ($past(wr_data) & SRC_MASK))) // R1
        else $error("enable write not taken");
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADR_ENABLE) |=> $stable(src_en)) // R1
        else $error("enable changed without write");
endmodule

// File: rtl/stat_hunt_flag.sv
// Module: stat_hunt_flag
// Hunt-state flag feeding the sync/hunt status source.
// Assumes: hunt_cmd and sync_found are single-cycle pulses; the hunt command wins a tie.
module stat_hunt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hunt_cmd,
    input  logic sync_found,
    output logic hunting
);
    // Purpose: set on a hunt command, clear on reported synchronization.
    always_ff @(posedge clk) begin
        if (!rst_n)          hunting <= 1'b0;
        else if (hunt_cmd)   hunting <= 1'b1;
        else if (sync_found) hunting <= 1'b0;
    end

    AST_HUNT_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> hunting) // R8
        else $error("hunt command did not set flag");
    AST_HUNT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_found && !hunt_cmd) |=> !hunting) // R8
        else $error("sync found did not clear flag");
endmodule

// File: rtl/stat_snap_latch.sv
// Module: stat_snap_latch
// Detects changes on enabled sources and freezes all enabled bits together.
// Assumes: live is the assembled source word; zero count is a one-cycle pulse.
// A reopen that coincides with a change leaves a retry flag so that the
// change closes the latch one cycle later instead of being dropped.
module stat_snap_latch
    import stat_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] live,
    input  logic [DATA_W-1:0] src_en,
    input  logic              reopen,
    output logic              closed,
    output logic [DATA_W-1:0] snap
);
    logic [DATA_W-1:0] prev_live;
    logic [DATA_W-1:0] level_hit;
    logic [DATA_W-1:0] pulse_hit;
    logic              trig;
    logic              retry;
    logic [DATA_W-1:0] retry_val;

    // Purpose: remember each source's value from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_live <= '0;
        else        prev_live <= live;
    end

    // Purpose: flag any enabled transition or an enabled zero-count pulse.
    always_comb begin
        level_hit = (live ^ prev_live) & src_en & LEVEL_MASK;
        pulse_hit = live & src_en & PULSE_MASK;
        trig      = |(level_hit | pulse_hit);
    end

    // Purpose: open, close and reload the shared snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            closed    <= 1'b0;
            snap      <= '0;
            retry     <= 1'b0;
            retry_val <= '0;
        end else if (reopen) begin
            closed    <= 1'b0;
            retry     <= trig;
            retry_val <= live;
        end else if (retry) begin
            closed    <= 1'b1;
            snap      <= retry_val;
            retry     <= 1'b0;
        end else if (!closed && trig) begin
            closed    <= 1'b1;
            snap      <= live;
        end
    end

    AST_CLOSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!closed && trig && !reopen && !retry) |=> (closed && snap == $past(live))) // R3
        else $error("enabled change did not close latch");
    AST_HOLD_WHILE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (closed && !reopen) |=> (closed && $stable(snap))) // R4
        else $error("closed latch moved");
    AST_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
        reopen |=> !closed) // R5
        else $error("reopen did not open latch");
    AST_RETRY_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (reopen && trig) |=> (!closed ##1 (reopen || closed))) // R10
        else $error("coincident change was lost");
endmodule

// File: rtl/stat_irq_latch.sv
// Module: stat_irq_latch (top)
// Status-change interrupt latch for one serial channel: enables, hunt flag,
// shared snapshot, status readback and interrupt-pending output.
// Assumes: inputs are synchronous to clk; reads are combinational on reg_addr.
module stat_irq_latch
    import stat_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              zc_pulse,
    input  logic              dcd_in,
    input  logic              cts_in,
    input  logic              txund_in,
    input  logic              brk_in,
    input  logic              hunt_cmd,
    input  logic              sync_found,
    input  logic              reopen_cmd,
    output logic              irq_pend
);
    logic [DATA_W-1:0] src_en;
    logic              master_en;
    logic              hunting;
    logic [DATA_W-1:0] live;
    logic              closed;
    logic [DATA_W-1:0] snap;
    logic [DATA_W-1:0] hold_mask;
    logic [DATA_W-1:0] status;

    stat_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_addr   (reg_addr),
        .wr_data   (reg_wdata),
        .src_en    (src_en),
        .master_en (master_en)
    );

    stat_hunt_flag u_hunt (
        .clk        (clk),
        .rst_n      (rst_n),
        .hunt_cmd   (hunt_cmd),
        .sync_found (sync_found),
        .hunting    (hunting)
    );

    // Purpose: place each source at its bit position; spare positions stay 0.
    always_comb begin
        live           = '0;
        live[BIT_BRK]  = brk_in;
        live[BIT_TXU]  = txund_in;
        live[BIT_CTS]  = cts_in;
        live[BIT_HUNT] = hunting;
        live[BIT_DCD]  = dcd_in;
        live[BIT_ZC]   = zc_pulse;
    end

    stat_snap_latch u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .live   (live),
        .src_en (src_en),
        .reopen (reopen_cmd),
        .closed (closed),
        .snap   (snap)
    );

    // Purpose: enabled bits read the snapshot while closed, all others read live.
    always_comb begin
        hold_mask = src_en & {DATA_W{closed}};
        status    = ((live & ~hold_mask) | (snap & hold_mask)) & SRC_MASK;
    end

    // Purpose: register read multiplexer.
    always_comb begin
        unique case (reg_addr)
            ADR_ENABLE: reg_rdata = src_en;
            ADR_MASTER: reg_rdata = {{(DATA_W-1){1'b0}}, master_en};
            ADR_STATUS: reg_rdata = status;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_pend = closed & master_en;

    AST_DISABLED_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (((status ^ live) & ~src_en & SRC_MASK) == '0)) // R2
        else $error("disabled source not live");
    AST_MASTER_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && !(reg_wr && reg_addr == ADR_MASTER)) |=> !irq_pend) // R7
        else $error("pending without master enable");
    AST_DISABLED_NO_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!closed && !reopen_cmd && src_en == '0 && !(reg_wr && reg_addr == ADR_ENABLE)) |=> !closed) // R6
        else $error("latch closed with all sources disabled");
endmodule

// File: tb/sim_stat_irq_latch.sv
`timescale 1ns/1ps
module sim_stat_irq_latch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       zc_pulse = 1'b0, dcd_in = 1'b0, cts_in = 1'b0, txund_in = 1'b0, brk_in = 1'b0;
    logic       hunt_cmd = 1'b0, sync_found = 1'b0, reopen_cmd = 1'b0;
    logic       irq_pend;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    stat_irq_latch u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .zc_pulse(zc_pulse),
        .dcd_in(dcd_in), .cts_in(cts_in), .txund_in(txund_in), .brk_in(brk_in),
        .hunt_cmd(hunt_cmd), .sync_found(sync_found), .reopen_cmd(reopen_cmd),
        .irq_pend(irq_pend)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One rising edge, then return at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic reopen();
        reopen_cmd = 1'b1;
        tick();
        reopen_cmd = 1'b0;
    endtask

    // R11: reset state
    task automatic t_reset();
        logic [7:0] d;
        rd(2'd0, d); check("R11 enables", d, 8'h00);
        rd(2'd1, d); check("R11 master", d, 8'h00);
        rd(2'd2, d); check("R11 status", d, 8'h00);
        check("R11 irq", {7'b0, irq_pend}, 8'h00);
    endtask

    // R1: register layout
    task automatic t_regs();
        logic [7:0] d;
        wr(2'd0, 8'hFF); rd(2'd0, d); check("R1 enable mask", d, 8'hFA);
        wr(2'd1, 8'hFF); rd(2'd1, d); check("R1 master bit", d, 8'h01);
        wr(2'd0, 8'h00); rd(2'd0, d); check("R1 enable clear", d, 8'h00);
    endtask

    // R2, R6: disabled sources are live and never interrupt
    task automatic t_disabled();
        logic [7:0] d;
        dcd_in = 1'b1; brk_in = 1'b1;
        rd(2'd2, d); check("R2 live while open", d, 8'h88);
        tick(); tick();
        check("R6 no irq from disabled", {7'b0, irq_pend}, 8'h00);
        dcd_in = 1'b0; brk_in = 1'b0;
        tick(); tick();
        check("R6 still no irq", {7'b0, irq_pend}, 8'h00);
    endtask

    // R3, R4, R5, R7: close on change, hold, reopen
    task automatic t_close_hold_reopen();
        logic [7:0] d;
        wr(2'd0, 8'h28);            // cts + dcd enabled, master already 1
        cts_in = 1'b1;
        rd(2'd2, d); check("R3 live before close", d, 8'h20);
        check("R3 no irq same cycle", {7'b0, irq_pend}, 8'h00);
        tick();
        check("R7 irq on close", {7'b0, irq_pend}, 8'h01);
        rd(2'd2, d); check("R3 frozen value", d, 8'h20);
        cts_in = 1'b0; dcd_in = 1'b1; brk_in = 1'b1;
        tick(); tick();
        rd(2'd2, d); check("R4 enabled frozen, disabled live", d, 8'hA0);
        check("R7 irq stays", {7'b0, irq_pend}, 8'h01);
        brk_in = 1'b0;
        reopen();
        check("R5 irq clears", {7'b0, irq_pend}, 8'h00);
        rd(2'd2, d); check("R5 live after reopen", d, 8'h08);
        tick();
        check("R5 stays open", {7'b0, irq_pend}, 8'h00);
    endtask

    // R7: master off still closes the latch
    task automatic t_master_off();
        logic [7:0] d;
        wr(2'd1, 8'h00);
        cts_in = 1'b1;
        tick();
        check("R7 no irq master off", {7'b0, irq_pend}, 8'h00);
        cts_in = 1'b0;
        tick();
        rd(2'd2, d); check("R7 latch closed anyway", d, 8'h28);
        wr(2'd1, 8'h01);
        check("R7 irq once master on", {7'b0, irq_pend}, 8'h01);
        reopen();
        check("R7 reopened", {7'b0, irq_pend}, 8'h00);
    endtask

    // R8: hunt flag both edges
    task automatic t_hunt();
        logic [7:0] d;
        wr(2'd0, 8'h10);
        hunt_cmd = 1'b1; tick(); hunt_cmd = 1'b0;
        rd(2'd2, d); check("R8 hunt set live", d & 8'h10, 8'h10);
        check("R8 not yet closed", {7'b0, irq_pend}, 8'h00);
        tick();
        check("R8 rising closes", {7'b0, irq_pend}, 8'h01);
        reopen();
        sync_found = 1'b1; tick(); sync_found = 1'b0;
        tick();
        check("R8 falling closes", {7'b0, irq_pend}, 8'h01);
        rd(2'd2, d); check("R8 frozen zero", d & 8'h10, 8'h00);
        reopen();
        hunt_cmd = 1'b1; sync_found = 1'b1; tick();
        hunt_cmd = 1'b0; sync_found = 1'b0;
        rd(2'd2, d); check("R8 hunt wins tie", d & 8'h10, 8'h10);
        tick();
        reopen();
        sync_found = 1'b1; tick(); sync_found = 1'b0; tick();
        reopen();
    endtask

    // R9: zero count pulse
    task automatic t_zero_count();
        logic [7:0] d;
        wr(2'd0, 8'h02);
        zc_pulse = 1'b1;
        rd(2'd2, d); check("R9 pulse level live", d & 8'h02, 8'h02);
        tick(); zc_pulse = 1'b0;
        check("R9 pulse closes", {7'b0, irq_pend}, 8'h01);
        tick();
        rd(2'd2, d); check("R9 frozen one", d & 8'h02, 8'h02);
        reopen();
        wr(2'd0, 8'h00);
        zc_pulse = 1'b1; tick(); zc_pulse = 1'b0; tick();
        check("R9 disabled pulse ignored", {7'b0, irq_pend}, 8'h00);
    endtask

    // R10: reopen and change in the same cycle
    task automatic t_coincident();
        logic [7:0] d;
        wr(2'd0, 8'h20);
        cts_in = 1'b0; dcd_in = 1'b0; tick();
        cts_in = 1'b1; tick();
        check("R10 closed first", {7'b0, irq_pend}, 8'h01);
        cts_in = 1'b0; reopen_cmd = 1'b1;
        tick();
        reopen_cmd = 1'b0;
        check("R10 open one cycle", {7'b0, irq_pend}, 8'h00);
        cts_in = 1'b1;
        tick();
        check("R10 closes again", {7'b0, irq_pend}, 8'h01);
        rd(2'd2, d); check("R10 frozen from change cycle", d & 8'h20, 8'h00);
        reopen();
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired (all requirements)");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        wr(2'd1, 8'h01);
        t_disabled();
        t_close_hold_reopen();
        t_master_off();
        t_hunt();
        t_zero_count();
        t_coincident();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule